// File: doc/BRIEF.md
# Smart Low-Side Switch Refresh Sequencer

This block is the SPI master for a 16-channel smart low-side switch. It holds the output word requested by the host. It writes that word to the switch as two OR-mode frames, one per 8-channel bank. Each refresh cycle also collects the two 16-bit diagnostic words. The switch answers every frame with the data for the previous command, so each diagnostic word arrives one frame late. A pending flag records that the upper-bank diagnostic is already queued in the switch, which lets every later cycle finish in two frames instead of three.

Up to eight channels (0..3 and 8..11) may be driven through parallel pins instead of SPI. Those channels are given by a static mask. Their bits are cleared from every SPI write, and the block drives the matching pins itself.

After reset the block runs a bring-up test, in this order:
1. It pulses the switch's reset line.
2. It checks an SPI echo loopback.
3. It drives the parallel pins low, then high, and reads them back over SPI each time.
4. It runs the first refresh.

A failed step latches a fail code and stops all SPI traffic until the next reset. After a passing bring-up, a cycle starts in either of two cases: a host write that changes a non-direct channel, or the expiry of a poll timer.

Top module: `sw_refresh_seq`

## Requirements
- R1: While rst_ni is low: drst_no=0, cs_no=1, sclk_o=0, ready_o=0, fail_o=0, fail_code_o=0, busy_o=0 and par_o=0.
- R2: After reset, drst_no stays low for RST_LO_CYC cycles. cs_no first falls RST_WAIT_CYC+1 cycles after drst_no rises.
- R3: Each frame is 16 bits, most significant bit first, with cs_no low for that frame only. sclk_o idles low. mosi_o changes on a rising sclk edge, and miso_i is sampled on a falling edge.
- R4: Bring-up sends these frames in order: 16'hA000 (echo), 16'h5555, 16'hF000, 16'hFF00, then 16'hC000 three times, then one refresh cycle. If the response to 16'h5555 is not 16'h5555, fail_code_o becomes 1.
- R5: par_o[3:0] drives channels 0..3 and par_o[7:4] drives channels 8..11. Only masked channels are ever driven high. Readback responses map channels 0..3 to rx[11:8] and channels 8..11 to rx[15:12].
   - The masked pins are held low until the response to the second 16'hC000 frame. Any masked bit read high in that response gives fail_code_o=2.
   - The masked pins are then driven high. Any masked bit read low in the response to the third 16'hC000 frame gives fail_code_o=3.
   - During the first refresh the masked pins stay high. After bring-up they follow the requested word.
- R6: A failure sets fail_o and a non-zero fail_code_o that hold until reset. ready_o stays low, and no further frame is sent, whether on poll expiry or on a host write.
- R7: The transmitted word is the requested word ANDed with the inverse of (dmask_i & 16'h0F0F). Bank 0 is sent as {8'h30, word[7:0]} and bank 1 as {8'h3F, word[15:8]}.
- R8: When no upper-bank diagnostic is pending (only the first refresh), the cycle has three frames: bank 0, whose response is dropped; bank 1, whose response goes to diag_lo_o; bank 1 again, whose response goes to diag_hi_o.
- R9: When the upper-bank diagnostic is pending, the cycle has two frames: bank 0, whose response goes to diag_hi_o; then bank 1, whose response goes to diag_lo_o.
- R10: cached_o takes the transmitted word in the cycle that busy_o falls, and ready_o rises at the end of the first refresh.
- R11: A write that changes a non-direct bit raises busy_o in the cycle after the write. A write of that kind made during a cycle starts another cycle, carrying the new word, right after the current one.
- R12: A write that changes only direct-channel bits sends no frame and leaves cached_o alone. It updates par_o.
- R13: With no write pending, busy_o stays low for exactly POLL_CYC cycles between two refresh cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the requested output word |
| wr_data_i | input | 16 | Requested output word, bit n = channel n |
| dmask_i | input | 16 | Static mask of channels driven by parallel pins, only 16'h0F0F honoured |
| miso_i | input | 1 | Serial data from the switch |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the switch |
| drst_no | output | 1 | Active-low reset to the switch |
| par_o | output | 8 | Parallel channel pins: [3:0] channels 0..3, [7:4] channels 8..11 |
| busy_o | output | 1 | Refresh cycle in progress |
| ready_o | output | 1 | Bring-up passed |
| fail_o | output | 1 | Bring-up failed (sticky) |
| fail_code_o | output | 3 | Failed step: 1 loopback, 2 pins stuck high, 3 pins stuck low |
| diag_lo_o | output | 16 | Diagnostic word of channels 0..7 |
| diag_hi_o | output | 16 | Diagnostic word of channels 8..15 |
| cached_o | output | 16 | Word last written to the switch |

## Verification
Most results fall on fixed cycles after a stimulus, and the bench samples each one there:
- busy_o is checked on the sample right after a qualifying write.
- The device-reset low time and the reset-release-to-first-select gap are counted sample by sample against RST_LO_CYC and RST_WAIT_CYC+1.
- The poll gap is counted against POLL_CYC.

Diagnostic words, cached_o and par_o are compared on the first sample after busy_o falls. A switch model in the bench answers every frame with the response to the previous command, and a scoreboard compares each finished frame against a queue of expected words. Quiet periods, such as a direct-only write or the time after a failure, are checked by counting select activity over a window longer than the poll interval.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {ST_RLO, ST_RWAIT, ST_BOOT, ST_CYC, ST_IDLE, ST_FAIL} seq_st_e;

  localparam logic [7:0]  CMD_OR_LO  = 8'h30;
  localparam logic [7:0]  CMD_OR_HI  = 8'h3F;
  localparam logic [7:0]  CMD_AND_LO = 8'hF0;
  localparam logic [7:0]  CMD_AND_HI = 8'hFF;
  localparam logic [7:0]  CMD_ECHO   = 8'hA0;
  localparam logic [7:0]  CMD_RDBK   = 8'hC0;
  localparam logic [15:0] LOOP_PAT   = 16'h5555;
  localparam logic [15:0] DIRECT_OK  = 16'h0F0F;

  localparam logic [2:0] FC_LOOP = 3'd1;
  localparam logic [2:0] FC_LOW  = 3'd2;
  localparam logic [2:0] FC_HIGH = 3'd3;

  // readback response -> channel map
  function automatic logic [15:0] rdbk_map(input logic [15:0] rx);
    return {4'h0, rx[15:12], 4'h0, rx[11:8]};
  endfunction

  // channel map -> parallel pin vector
  function automatic logic [7:0] pins_of(input logic [15:0] ch);
    return {ch[11:8], ch[3:0]};
  endfunction
endpackage

// File: rtl/srs_spi_shift.sv
module srs_spi_shift #(
  parameter int HALF_DIV = 25,
  parameter int W        = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  input  logic         miso_i,
  output logic         sclk_o,
  output logic         cs_no,
  output logic         mosi_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PW = $clog2(2 * W);

  typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_BITS, SH_TRAIL, SH_GAP} sh_e;

  sh_e           st_q;
  logic [DW-1:0] cnt_q;
  logic [PW-1:0] ph_q;
  logic [W-1:0]  tx_q, rx_q;
  logic          sclk_q, cs_q, mosi_q, done_q;
  logic          tick;

  assign tick = (cnt_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      ph_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == SH_IDLE) cnt_q <= '0;
      else                 cnt_q <= tick ? '0 : cnt_q + DW'(1);
      case (st_q)
        SH_IDLE: if (start_i) begin
          tx_q <= tx_i;
          cs_q <= 1'b0;
          st_q <= SH_LEAD;
        end
        SH_LEAD: if (tick) begin
          ph_q <= '0;
          st_q <= SH_BITS;
        end
        SH_BITS: if (tick) begin
          ph_q <= ph_q + PW'(1);
          if (!ph_q[0]) begin
            // rising edge: launch next bit
            sclk_q <= 1'b1;
            mosi_q <= tx_q[W-1];
            tx_q   <= {tx_q[W-2:0], 1'b0};
          end else begin
            // falling edge: capture
            sclk_q <= 1'b0;
            rx_q   <= {rx_q[W-2:0], miso_i};
            if (ph_q == PW'(2 * W - 1)) st_q <= SH_TRAIL;
          end
        end
        SH_TRAIL: if (tick) begin
          cs_q   <= 1'b1;
          mosi_q <= 1'b0;
          st_q   <= SH_GAP;
        end
        SH_GAP: if (tick) begin
          done_q <= 1'b1;
          st_q   <= SH_IDLE;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign cs_no  = cs_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/srs_frame_enc.sv
module srs_frame_enc
  import srs_pkg::*;
(
  input  seq_st_e     st_i,
  input  logic [2:0]  idx_i,
  input  logic [15:0] word_i,
  output logic [15:0] tx_o
);
  always_comb begin
    tx_o = 16'h0000;
    if (st_i == ST_BOOT) begin
      case (idx_i)
        3'd0:    tx_o = {CMD_ECHO, 8'h00};
        3'd1:    tx_o = LOOP_PAT;
        3'd2:    tx_o = {CMD_AND_LO, 8'h00};
        3'd3:    tx_o = {CMD_AND_HI, 8'h00};
        default: tx_o = {CMD_RDBK, 8'h00};
      endcase
    end else if (st_i == ST_CYC) begin
      tx_o = (idx_i == 3'd0) ? {CMD_OR_LO, word_i[7:0]} : {CMD_OR_HI, word_i[15:8]};
    end
  end
endmodule

// File: rtl/sw_refresh_seq.sv
module sw_refresh_seq
  import srs_pkg::*;
#(
  parameter int HALF_DIV     = 25,
  parameter int RST_LO_CYC   = 250000,
  parameter int RST_WAIT_CYC = 2500000,
  parameter int POLL_CYC     = 2500000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic [15:0] dmask_i,
  input  logic        miso_i,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  output logic        drst_no,
  output logic [7:0]  par_o,
  output logic        busy_o,
  output logic        ready_o,
  output logic        fail_o,
  output logic [2:0]  fail_code_o,
  output logic [15:0] diag_lo_o,
  output logic [15:0] diag_hi_o,
  output logic [15:0] cached_o
);
  localparam int FRAME_W = 16;
  localparam int T_A     = (RST_LO_CYC > RST_WAIT_CYC) ? RST_LO_CYC : RST_WAIT_CYC;
  localparam int T_MAX   = (T_A > POLL_CYC) ? T_A : POLL_CYC;
  localparam int TW      = $clog2(T_MAX + 1);

  seq_st_e     st_q;
  logic [TW-1:0] tmr_q;
  logic [2:0]  idx_q;
  logic        inflight_q, pend_q, trig_q, par_hi_q, cyc3_q, up_q;
  logic [2:0]  fcode_q;
  logic [15:0] req_q, out_q, cached_q, dlo_q, dhi_q;

  logic [15:0] msk, req_nxt, rx_w, rx_map, tx_w, chan;
  logic        wr_hit, poll_hit, sh_start, sh_done;

  assign msk      = dmask_i & DIRECT_OK;
  assign req_nxt  = wr_en_i ? wr_data_i : req_q;
  assign wr_hit   = wr_en_i && (((wr_data_i ^ req_q) & ~msk) != 16'h0000);
  assign poll_hit = (tmr_q == TW'(POLL_CYC - 1));
  assign sh_start = ((st_q == ST_BOOT) || (st_q == ST_CYC)) && !inflight_q;
  assign rx_map   = rdbk_map(rx_w) & msk;

  srs_frame_enc u_enc (
    .st_i  (st_q),
    .idx_i (idx_q),
    .word_i(out_q),
    .tx_o  (tx_w)
  );

  srs_spi_shift #(.HALF_DIV(HALF_DIV), .W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sh_start),
    .tx_i   (tx_w),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .cs_no  (cs_no),
    .mosi_o (mosi_o),
    .done_o (sh_done),
    .rx_o   (rx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RLO;
      tmr_q      <= '0;
      idx_q      <= '0;
      inflight_q <= 1'b0;
      pend_q     <= 1'b0;
      trig_q     <= 1'b0;
      par_hi_q   <= 1'b0;
      cyc3_q     <= 1'b0;
      up_q       <= 1'b0;
      fcode_q    <= '0;
      req_q      <= '0;
      out_q      <= '0;
      cached_q   <= '0;
      dlo_q      <= '0;
      dhi_q      <= '0;
    end else begin
      if (wr_en_i) req_q <= wr_data_i;
      if (sh_start)     inflight_q <= 1'b1;
      else if (sh_done) inflight_q <= 1'b0;

      case (st_q)
        ST_RLO: begin
          if (tmr_q == TW'(RST_LO_CYC - 1)) begin
            tmr_q <= '0;
            st_q  <= ST_RWAIT;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_RWAIT: begin
          if (tmr_q == TW'(RST_WAIT_CYC - 1)) begin
            tmr_q <= '0;
            idx_q <= '0;
            st_q  <= ST_BOOT;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_BOOT: begin
          if (wr_hit) trig_q <= 1'b1;
          if (sh_done) begin
            idx_q <= idx_q + 3'd1;
            case (idx_q)
              3'd1: if (rx_w != LOOP_PAT) begin
                st_q    <= ST_FAIL;
                fcode_q <= FC_LOOP;
              end
              3'd3: dlo_q <= rx_w;
              3'd4: dhi_q <= rx_w;
              3'd5: begin
                if (rx_map != 16'h0000) begin
                  st_q    <= ST_FAIL;
                  fcode_q <= FC_LOW;
                end else par_hi_q <= 1'b1;
              end
              3'd6: begin
                if (rx_map != msk) begin
                  st_q    <= ST_FAIL;
                  fcode_q <= FC_HIGH;
                end else begin
                  st_q   <= ST_CYC;
                  idx_q  <= '0;
                  cyc3_q <= !pend_q;
                  out_q  <= req_nxt & ~msk;
                  trig_q <= 1'b0;
                end
              end
              default: ;
            endcase
          end
        end
        ST_CYC: begin
          if (wr_hit) trig_q <= 1'b1;
          if (sh_done) begin
            idx_q <= idx_q + 3'd1;
            if (idx_q == 3'd0) begin
              if (!cyc3_q) dhi_q <= rx_w;
            end else if (idx_q == 3'd1) begin
              dlo_q <= rx_w;
              if (!cyc3_q) begin
                st_q     <= ST_IDLE;
                cached_q <= out_q;
                pend_q   <= 1'b1;
                up_q     <= 1'b1;
                tmr_q    <= '0;
              end
            end else begin
              dhi_q    <= rx_w;
              st_q     <= ST_IDLE;
              cached_q <= out_q;
              pend_q   <= 1'b1;
              up_q     <= 1'b1;
              tmr_q    <= '0;
            end
          end
        end
        ST_IDLE: begin
          if (trig_q || wr_hit || poll_hit) begin
            st_q   <= ST_CYC;
            idx_q  <= '0;
            cyc3_q <= !pend_q;
            out_q  <= req_nxt & ~msk;
            trig_q <= 1'b0;
            tmr_q  <= '0;
          end else tmr_q <= tmr_q + TW'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (st_q == ST_FAIL) chan = 16'h0000;
    else if (up_q)       chan = req_q & msk;
    else if (par_hi_q)   chan = msk;
    else                 chan = 16'h0000;
  end

  assign par_o       = pins_of(chan);
  assign drst_no     = (st_q != ST_RLO);
  assign busy_o      = (st_q == ST_CYC);
  assign ready_o     = up_q;
  assign fail_o      = (st_q == ST_FAIL);
  assign fail_code_o = fcode_q;
  assign diag_lo_o   = dlo_q;
  assign diag_hi_o   = dhi_q;
  assign cached_o    = cached_q;
endmodule

// File: rtl/srs_chk.sv
module srs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_no,
  input logic        sclk_o,
  input logic        drst_no,
  input logic        ready_o,
  input logic        fail_o,
  input logic [2:0]  fail_code_o,
  input logic        busy_o,
  input logic [15:0] cached_o,
  input logic [7:0]  par_o,
  input logic [15:0] dmask_i
);
  logic [15:0] par_ch;
  assign par_ch = {4'h0, par_o[7:4], 4'h0, par_o[3:0]};

  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_no_frame_in_drst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drst_no |-> cs_no);

  assert_fail_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);

  assert_fail_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (cs_no && !ready_o && !busy_o && (fail_code_o != 3'd0)));

  assert_code_only_on_fail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_code_o != 3'd0) |-> fail_o);

  assert_ready_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  assert_cache_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cached_o) |-> $fell(busy_o));

  assert_par_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_ch & ~(dmask_i & 16'h0F0F)) == 16'h0000);
endmodule

bind sw_refresh_seq srs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_no      (cs_no),
  .sclk_o     (sclk_o),
  .drst_no    (drst_no),
  .ready_o    (ready_o),
  .fail_o     (fail_o),
  .fail_code_o(fail_code_o),
  .busy_o     (busy_o),
  .cached_o   (cached_o),
  .par_o      (par_o),
  .dmask_i    (dmask_i)
);

// File: tb/sim_sw_refresh_seq.sv
module sim_sw_refresh_seq;
  localparam int HD   = 2;
  localparam int RLO  = 40;
  localparam int RW   = 100;
  localparam int POLL = 3000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] dmask = 16'h0305;
  logic        miso, sclk, cs_n, mosi, drst_n, busy, ready, fail;
  logic [7:0]  par;
  logic [2:0]  fcode;
  logic [15:0] dlo, dhi, cached;

  sw_refresh_seq #(.HALF_DIV(HD), .RST_LO_CYC(RLO), .RST_WAIT_CYC(RW), .POLL_CYC(POLL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data), .dmask_i(dmask),
    .miso_i(miso), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .drst_no(drst_n),
    .par_o(par), .busy_o(busy), .ready_o(ready), .fail_o(fail), .fail_code_o(fcode),
    .diag_lo_o(dlo), .diag_hi_o(dhi), .cached_o(cached)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // switch model: each frame answers the previous command
  int          fault = 0;
  logic [15:0] d0 = 16'hFFF3, d1 = 16'hCFFF;
  logic [7:0]  prev_cmd = 8'h00;
  logic        echo_on = 1'b0;
  logic [15:0] resp = '0, rxw = '0;
  logic        miso_r = 1'b0;

  assign miso = (echo_on && fault != 1) ? mosi : miso_r;

  always @(negedge drst_n) begin
    prev_cmd = 8'h00;
    echo_on  = 1'b0;
  end

  always @(negedge cs_n) begin
    logic [7:0] pv;
    pv = (fault == 2) ? 8'hFF : (fault == 3) ? 8'h00 : par;
    echo_on = (prev_cmd == 8'hA0);
    case (prev_cmd)
      8'h30, 8'hF0: resp = d0;
      8'h3F, 8'hFF: resp = d1;
      8'hC0:        resp = {pv[7:4], pv[3:0], 8'h5A};
      default:      resp = 16'h0000;
    endcase
    rxw = '0;
  end

  always @(posedge sclk) begin
    miso_r = resp[15];
    resp   = {resp[14:0], 1'b0};
  end

  always @(negedge sclk) rxw = {rxw[14:0], mosi};

  // scoreboard monitor
  always @(posedge cs_n) begin
    if (rst_ni === 1'b1) begin
      if (exp_q.size() == 0) chk("R4 R6 R12 unexpected frame", {16'h0, rxw}, 32'hFFFFFFFF);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk("R3 R4 R7 frame word", {16'h0, rxw}, {16'h0, e});
      end
      prev_cmd = rxw[15:8];
    end
  end

  task automatic push_boot(input int n);
    logic [15:0] seq [7];
    seq = '{16'hA000, 16'h5555, 16'hF000, 16'hFF00, 16'hC000, 16'hC000, 16'hC000};
    for (int i = 0; i < n; i++) exp_q.push_back(seq[i]);
  endtask

  task automatic write_word(input logic [15:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic fail_run(input int f, input int nfr, input logic [2:0] code);
    int cnt;
    rst_ni = 1'b0;
    exp_q.delete();
    fault = f;
    push_boot(nfr);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    while (!fail && !ready) @(negedge clk);
    chk("R6 fail flag", {31'h0, fail}, 32'h1);
    chk("R4 R5 R6 fail code", {29'h0, fcode}, {29'h0, code});
    chk("R6 ready low", {31'h0, ready}, 32'h0);
    write_word(16'h8000);
    cnt = 0;
    for (int i = 0; i < POLL + 200; i++) begin
      if (!cs_n || busy) cnt++;
      @(negedge clk);
    end
    chk("R6 quiet after fail", cnt, 0);
    chk("R6 frames consumed", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    push_boot(7);
    exp_q.push_back(16'h3000);
    exp_q.push_back(16'h3F00);
    exp_q.push_back(16'h3F00);
    repeat (3) @(negedge clk);
    chk("R1 drst_no", {31'h0, drst_n}, 32'h0);
    chk("R1 cs_no", {31'h0, cs_n}, 32'h1);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
    chk("R1 flags", {28'h0, ready, fail, busy, 1'b0}, 32'h0);
    chk("R1 code/par", {21'h0, fcode, par}, 32'h0);

    rst_ni = 1'b1;
    cnt = 0;
    while (!drst_n && cnt < 100000) begin cnt++; @(negedge clk); end
    chk("R2 reset low time", cnt, RLO);
    cnt = 0;
    while (cs_n && cnt < 100000) begin cnt++; @(negedge clk); end
    chk("R2 wait before first frame", cnt, RW + 1);

    while (!busy) @(negedge clk);
    chk("R5 pins high in first refresh", {24'h0, par}, 32'h35);
    while (!ready && !fail) @(negedge clk);
    chk("R4 bring-up passes", {29'h0, ready, fail, 1'b0}, 32'h4);
    chk("R4 all boot frames sent", exp_q.size(), 0);
    chk("R8 diag lo", {16'h0, dlo}, {16'h0, d0});
    chk("R8 diag hi", {16'h0, dhi}, {16'h0, d1});
    chk("R10 cached after boot", {16'h0, cached}, 32'h0);
    chk("R5 pins follow request", {24'h0, par}, 32'h0);

    // two-frame cycle, masked word
    d0 = 16'h1234; d1 = 16'h5678;
    exp_q.push_back(16'h30F0);
    exp_q.push_back(16'h3FA4);
    write_word(16'hA5F0);
    chk("R11 busy after write", {31'h0, busy}, 32'h1);
    wait_idle();
    chk("R9 diag hi", {16'h0, dhi}, 32'h5678);
    chk("R9 diag lo", {16'h0, dlo}, 32'h1234);
    chk("R7 R10 cached", {16'h0, cached}, 32'hA4F0);
    chk("R5 par after write", {24'h0, par}, 32'h10);

    // direct-only change
    write_word(16'hA5F1);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (busy || !cs_n) cnt++;
      @(negedge clk);
    end
    chk("R12 no frame", cnt, 0);
    chk("R12 par updated", {24'h0, par}, 32'h11);
    chk("R12 cached kept", {16'h0, cached}, 32'hA4F0);

    d0 = 16'hBEEF; d1 = 16'hCAFE;
    exp_q.push_back(16'h30FA);
    exp_q.push_back(16'h3F00);
    write_word(16'h00FF);
    chk("R11 busy after write 2", {31'h0, busy}, 32'h1);
    wait_idle();
    chk("R9 diag hi 2", {16'h0, dhi}, 32'hCAFE);
    chk("R9 diag lo 2", {16'h0, dlo}, 32'hBEEF);
    chk("R7 cached 2", {16'h0, cached}, 32'h00FA);
    chk("R5 par 2", {24'h0, par}, 32'h05);

    // poll-driven cycle
    d0 = 16'h0F0F; d1 = 16'hF0F0;
    exp_q.push_back(16'h30FA);
    exp_q.push_back(16'h3F00);
    cnt = 0;
    while (!busy && cnt < 100000) begin cnt++; @(negedge clk); end
    chk("R13 poll gap", cnt, POLL);
    wait_idle();
    chk("R13 poll diag hi", {16'h0, dhi}, 32'hF0F0);
    chk("R13 poll diag lo", {16'h0, dlo}, 32'h0F0F);

    // write during a cycle
    exp_q.push_back(16'h3000);
    exp_q.push_back(16'h3F10);
    exp_q.push_back(16'h3000);
    exp_q.push_back(16'h3F20);
    write_word(16'h1100);
    chk("R11 busy after write 3", {31'h0, busy}, 32'h1);
    repeat (20) @(negedge clk);
    write_word(16'h2200);
    while (!(exp_q.size() == 0 && !busy)) @(negedge clk);
    chk("R11 queued write applied", {16'h0, cached}, 32'h2000);

    fail_run(1, 2, 3'd1);
    fail_run(2, 6, 3'd2);
    fail_run(3, 7, 3'd3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule